// File: doc/BRIEF.md
# Mode-Dependent Sync Signal Generator

This block produces the horizontal and vertical sync timing for a CCD drive. A pixel-clock counter divides time into lines of a fixed clock count. A line counter groups those lines into fields. The field length depends on the selected drive mode and on a choice between an NTSC-like and a PAL-like standard.

Each field is a whole number of lines followed by a partial line of a mode-specific number of clocks. In the full-read mode, successive fields alternate between A and B. Two further codes force every field to be A or every field to be B.

The block exports active-low line and field strobes. It also exports its horizontal and line counts, so downstream pulse decoders can compare against them, and a field flag. With the internal generator disabled, the strobes come from external sync inputs. The counters then follow the falling edges of those inputs.

Top module: `ccd_sync_gen`

## Requirements
- R1: With `int_en_i` high, `h_cnt_o` advances by one each clock from 0 to LINE_CLKS-1 and returns to 0 at each line start. `hd_o` is low exactly while `h_cnt_o` < HD_W.
- R2: A field lasts lines×LINE_CLKS + tail clocks, measured between successive falling edges of `vd_o`. The lines and tail values come from table entry {`pal_i`, kind}, where `pal_i`=1 selects PAL and 0 selects NTSC. The kind is taken from `mode_i` as follows: 000, 100 and 111 give draft (kind 0); 001 gives AF1 (kind 1); 010 gives AF2 (kind 2); 011, 101 and 110 give frame (kind 3). The default entries are: NTSC draft 224/1372, AF1 112/1372, AF2 56/686, frame 1012/1672; PAL draft 269/2039, AF1 134/2354, AF2 67/1178, frame 944/464.
- R3: After the last whole line, `v_cnt_o` equals the line count while `h_cnt_o` runs from 0 to tail-1. The next clock starts a new field with both counts at 0. A tail of 0 wraps straight from the last whole line.
- R4: With `int_en_i` high, `vd_o` is low exactly while `v_cnt_o` < VD_LINES.
- R5: `mode_i` and `pal_i` are sampled only at the first clock of a new field. A change made during a field leaves that field's length unchanged.
- R6: Under mode 011, `field_b_o` (0 = A, 1 = B) toggles at each field start if the previous field used a frame code. Otherwise it starts at A.
- R7: Mode 101 sets `field_b_o` to 0 and mode 110 sets it to 1 at every field start. All non-frame codes set it to 0.
- R8: With `int_en_i` low, `hd_o` and `vd_o` equal `ext_hd_i` and `ext_vd_i` delayed by one clock. A sampled falling edge of `ext_hd_i` zeroes `h_cnt_o` and advances `v_cnt_o`. A sampled falling edge of `ext_vd_i` zeroes `v_cnt_o` and starts a new field as in R5–R7.
- R9: Reset gives `h_cnt_o`=0, `v_cnt_o`=0, `field_b_o`=0, and both strobes low. The first field after reset uses NTSC draft timing regardless of `mode_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_en_i | input | 1 | 1 = internal generator, 0 = follow external sync |
| mode_i | input | 3 | Drive mode code |
| pal_i | input | 1 | 1 = PAL-like lengths, 0 = NTSC-like |
| ext_hd_i | input | 1 | External line sync, active low |
| ext_vd_i | input | 1 | External field sync, active low |
| hd_o | output | 1 | Line strobe, active low |
| vd_o | output | 1 | Field strobe, active low |
| h_cnt_o | output | $clog2(LINE_CLKS) | Horizontal count |
| v_cnt_o | output | VCNT_W | Line count within field |
| field_b_o | output | 1 | Field flag, 0 = A, 1 = B |

## Verification
The bench shrinks the line and field tables so that all eight table entries can be run. These include a zero tail, a one-clock tail and a tail one short of a full line, which separates off-by-one errors in the wrap logic. Every mode code is applied, including the aliases 100 and 111 and mid-field changes, to show that only field boundaries load the configuration. Sequences of frame, forced-B and forced-A codes separate correct alternation from a stuck or mis-reset field flag. An external-sync stretch with irregular pulse spacing shows that the counters follow input edges rather than their own period.

// File: rtl/ccd_sync_pkg.sv
package ccd_sync_pkg;

  typedef enum logic [1:0] {
    K_DRAFT = 2'd0,
    K_AF1   = 2'd1,
    K_AF2   = 2'd2,
    K_FRAME = 2'd3
  } fkind_e;

  localparam logic [2:0] M_AF1     = 3'b001;
  localparam logic [2:0] M_AF2     = 3'b010;
  localparam logic [2:0] M_FRAME   = 3'b011;
  localparam logic [2:0] M_FRAME_A = 3'b101;
  localparam logic [2:0] M_FRAME_B = 3'b110;

  function automatic fkind_e kind_of(input logic [2:0] m);
    case (m)
      M_AF1:                         return K_AF1;
      M_AF2:                         return K_AF2;
      M_FRAME, M_FRAME_A, M_FRAME_B: return K_FRAME;
      default:                       return K_DRAFT;
    endcase
  endfunction

  // field flag for the field about to start
  function automatic logic next_field(input logic [2:0] nm, input logic [2:0] cm,
                                      input logic fb);
    case (nm)
      M_FRAME:   return (kind_of(cm) == K_FRAME) ? ~fb : 1'b0;
      M_FRAME_B: return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ccd_sync_cfg.sv
module ccd_sync_cfg
  import ccd_sync_pkg::*;
#(
  parameter int HCNT_W = 12,
  parameter int VCNT_W = 11,
  parameter logic [7:0][15:0] FIELD_LINES = '0,
  parameter logic [7:0][15:0] FIELD_TAIL  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [2:0]        mode_i,
  input  logic              pal_i,
  output logic [2:0]        act_mode_o,
  output logic              field_b_o,
  output logic [VCNT_W-1:0] lines_o,
  output logic [HCNT_W-1:0] tail_o
);

  logic [2:0] act_mode_q;
  logic       act_pal_q;
  logic       field_b_q;
  logic [2:0] idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_mode_q <= 3'b000;
      act_pal_q  <= 1'b0;
      field_b_q  <= 1'b0;
    end else if (load_i) begin
      field_b_q  <= next_field(mode_i, act_mode_q, field_b_q);
      act_mode_q <= mode_i;
      act_pal_q  <= pal_i;
    end
  end

  assign idx        = {act_pal_q, 2'(kind_of(act_mode_q))};
  assign lines_o    = FIELD_LINES[idx][VCNT_W-1:0];
  assign tail_o     = FIELD_TAIL[idx][HCNT_W-1:0];
  assign act_mode_o = act_mode_q;
  assign field_b_o  = field_b_q;

endmodule

// File: rtl/ccd_sync_cnt.sv
module ccd_sync_cnt #(
  parameter int LINE_CLKS = 2670,
  parameter int HCNT_W    = 12,
  parameter int VCNT_W    = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              int_en_i,
  input  logic              ext_hd_i,
  input  logic              ext_vd_i,
  input  logic [VCNT_W-1:0] lines_i,
  input  logic [HCNT_W-1:0] tail_i,
  output logic              field_start_o,
  output logic [HCNT_W-1:0] h_cnt_o,
  output logic [VCNT_W-1:0] v_cnt_o,
  output logic              ext_hd_q_o,
  output logic              ext_vd_q_o
);

  localparam logic [HCNT_W-1:0] H_LAST = HCNT_W'(LINE_CLKS - 1);
  localparam logic [VCNT_W-1:0] V_MAX  = '1;

  logic [HCNT_W-1:0] h_q, h_d, h_sat;
  logic [VCNT_W-1:0] v_q, v_d, v_sat;
  logic              ehd_q, evd_q;
  logic              line_end, tail_zero, last_line, tail_done, wrap_int;
  logic              hd_fall, vd_fall;

  assign line_end  = (h_q == H_LAST);
  assign tail_zero = (tail_i == '0);
  // ">=" keeps the wrap reachable after counts inherited from external sync
  assign last_line = tail_zero ? (v_q >= lines_i - VCNT_W'(1)) : (v_q >= lines_i);
  assign tail_done = !tail_zero && (v_q >= lines_i) && (h_q == tail_i - HCNT_W'(1));
  assign wrap_int  = (line_end && last_line) || tail_done;

  assign hd_fall = ehd_q && !ext_hd_i;
  assign vd_fall = evd_q && !ext_vd_i;

  assign h_sat = line_end ? h_q : h_q + HCNT_W'(1);
  assign v_sat = (v_q == V_MAX) ? v_q : v_q + VCNT_W'(1);

  assign field_start_o = int_en_i ? wrap_int : vd_fall;

  always_comb begin
    h_d = h_sat;
    v_d = v_q;
    if (int_en_i) begin
      if (wrap_int) begin
        h_d = '0;
        v_d = '0;
      end else if (line_end) begin
        h_d = '0;
        v_d = v_sat;
      end
    end else begin
      if (vd_fall) begin
        v_d = '0;
        if (hd_fall) h_d = '0;
      end else if (hd_fall) begin
        h_d = '0;
        v_d = v_sat;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q   <= '0;
      v_q   <= '0;
      ehd_q <= 1'b1;
      evd_q <= 1'b1;
    end else begin
      h_q   <= h_d;
      v_q   <= v_d;
      ehd_q <= ext_hd_i;
      evd_q <= ext_vd_i;
    end
  end

  assign h_cnt_o    = h_q;
  assign v_cnt_o    = v_q;
  assign ext_hd_q_o = ehd_q;
  assign ext_vd_q_o = evd_q;

endmodule

// File: rtl/ccd_sync_strobe.sv
module ccd_sync_strobe #(
  parameter int HD_W     = 24,
  parameter int VD_LINES = 3,
  parameter int HCNT_W   = 12,
  parameter int VCNT_W   = 11
) (
  input  logic              int_en_i,
  input  logic [HCNT_W-1:0] h_cnt_i,
  input  logic [VCNT_W-1:0] v_cnt_i,
  input  logic              ext_hd_q_i,
  input  logic              ext_vd_q_i,
  output logic              hd_o,
  output logic              vd_o
);

  localparam logic [HCNT_W-1:0] HD_END = HCNT_W'(HD_W);
  localparam logic [VCNT_W-1:0] VD_END = VCNT_W'(VD_LINES);

  logic hd_int, vd_int;

  assign hd_int = (h_cnt_i >= HD_END);
  assign vd_int = (v_cnt_i >= VD_END);

  assign hd_o = int_en_i ? hd_int : ext_hd_q_i;
  assign vd_o = int_en_i ? vd_int : ext_vd_q_i;

endmodule

// File: rtl/ccd_sync_gen.sv
module ccd_sync_gen #(
  parameter int LINE_CLKS = 2670,
  parameter int VCNT_W    = 11,
  parameter int HD_W      = 24,
  parameter int VD_LINES  = 3,
  parameter logic [7:0][15:0] FIELD_LINES = {16'd944, 16'd67, 16'd134, 16'd269,
                                             16'd1012, 16'd56, 16'd112, 16'd224},
  parameter logic [7:0][15:0] FIELD_TAIL  = {16'd464, 16'd1178, 16'd2354, 16'd2039,
                                             16'd1672, 16'd686, 16'd1372, 16'd1372},
  localparam int HCNT_W = $clog2(LINE_CLKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              int_en_i,
  input  logic [2:0]        mode_i,
  input  logic              pal_i,
  input  logic              ext_hd_i,
  input  logic              ext_vd_i,
  output logic              hd_o,
  output logic              vd_o,
  output logic [HCNT_W-1:0] h_cnt_o,
  output logic [VCNT_W-1:0] v_cnt_o,
  output logic              field_b_o
);

  logic              field_start;
  logic [2:0]        act_mode;
  logic [VCNT_W-1:0] lines;
  logic [HCNT_W-1:0] tail;
  logic              ehd_q, evd_q;

  ccd_sync_cfg #(
    .HCNT_W(HCNT_W), .VCNT_W(VCNT_W),
    .FIELD_LINES(FIELD_LINES), .FIELD_TAIL(FIELD_TAIL)
  ) i_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(field_start),
    .mode_i(mode_i), .pal_i(pal_i),
    .act_mode_o(act_mode), .field_b_o(field_b_o),
    .lines_o(lines), .tail_o(tail)
  );

  ccd_sync_cnt #(
    .LINE_CLKS(LINE_CLKS), .HCNT_W(HCNT_W), .VCNT_W(VCNT_W)
  ) i_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .int_en_i(int_en_i),
    .ext_hd_i(ext_hd_i), .ext_vd_i(ext_vd_i),
    .lines_i(lines), .tail_i(tail),
    .field_start_o(field_start),
    .h_cnt_o(h_cnt_o), .v_cnt_o(v_cnt_o),
    .ext_hd_q_o(ehd_q), .ext_vd_q_o(evd_q)
  );

  ccd_sync_strobe #(
    .HD_W(HD_W), .VD_LINES(VD_LINES), .HCNT_W(HCNT_W), .VCNT_W(VCNT_W)
  ) i_strobe (
    .int_en_i(int_en_i), .h_cnt_i(h_cnt_o), .v_cnt_i(v_cnt_o),
    .ext_hd_q_i(ehd_q), .ext_vd_q_i(evd_q),
    .hd_o(hd_o), .vd_o(vd_o)
  );

endmodule

// File: rtl/ccd_sync_gen_chk.sv
module ccd_sync_gen_chk #(
  parameter int LINE_CLKS = 2670,
  parameter int VCNT_W    = 11,
  parameter int HCNT_W    = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              int_en_i,
  input logic              ext_hd_i,
  input logic              hd_o,
  input logic              vd_o,
  input logic [HCNT_W-1:0] h_cnt_o,
  input logic [VCNT_W-1:0] v_cnt_o,
  input logic              field_b_o,
  input logic [2:0]        act_mode
);

  a_r1_h_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_cnt_o < HCNT_W'(LINE_CLKS));

  a_r1_h_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_en_i && h_cnt_o != HCNT_W'(LINE_CLKS - 1)) |=>
      (h_cnt_o == '0) || (h_cnt_o == HCNT_W'($past(h_cnt_o) + 1'b1)));

  a_r1_hd_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_en_i && h_cnt_o == '0) |-> !hd_o);

  a_r4_vd_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_en_i && v_cnt_o == '0) |-> !vd_o);

  a_r5_cfg_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mode != $past(act_mode)) |-> (v_cnt_o == '0));

  a_r7_force_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mode == 3'b110) |-> field_b_o);

  a_r7_force_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mode == 3'b101) |-> !field_b_o);

  a_r8_ext_hd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_en_i && $past(rst_ni)) |-> (hd_o == $past(ext_hd_i)));

endmodule

bind ccd_sync_gen ccd_sync_gen_chk #(
  .LINE_CLKS(LINE_CLKS), .VCNT_W(VCNT_W), .HCNT_W(HCNT_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .int_en_i(int_en_i), .ext_hd_i(ext_hd_i),
  .hd_o(hd_o), .vd_o(vd_o), .h_cnt_o(h_cnt_o), .v_cnt_o(v_cnt_o),
  .field_b_o(field_b_o), .act_mode(act_mode)
);

// File: tb/test_ccd_sync_gen.sv
module test_ccd_sync_gen;

  localparam int LINE = 20;
  localparam int HDW  = 3;
  localparam int VDL  = 1;
  localparam int VW   = 11;

  // index {pal,kind}: 0..3 NTSC draft/af1/af2/frame, 4..7 PAL
  int ltab [8] = '{4, 3, 2, 5, 5, 4, 2, 6};
  int ttab [8] = '{7, 5, 0, 13, 11, 19, 1, 9};

  logic          clk = 0, rst_n = 0, int_en = 1, pal = 0;
  logic [2:0]    mode = 3'b010;
  logic          ext_hd = 1, ext_vd = 1;
  logic          hd, vd, fb;
  logic [4:0]    hc;
  logic [VW-1:0] vc;

  int errors = 0, checks = 0, cyc = 0;

  ccd_sync_gen #(
    .LINE_CLKS(LINE), .VCNT_W(VW), .HD_W(HDW), .VD_LINES(VDL),
    .FIELD_LINES({16'd6, 16'd2, 16'd4, 16'd5, 16'd5, 16'd2, 16'd3, 16'd4}),
    .FIELD_TAIL ({16'd9, 16'd1, 16'd19, 16'd11, 16'd13, 16'd0, 16'd5, 16'd7})
  ) i_ccd_sync_gen (
    .clk_i(clk), .rst_ni(rst_n), .int_en_i(int_en), .mode_i(mode), .pal_i(pal),
    .ext_hd_i(ext_hd), .ext_vd_i(ext_vd), .hd_o(hd), .vd_o(vd),
    .h_cnt_o(hc), .v_cnt_o(vc), .field_b_o(fb)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_h = 0, m_v = 0, m_mode = 0;
  bit m_fb = 0, m_pal = 0, m_ehq = 1, m_evq = 1;

  function automatic int kind(input int m);
    case (m)
      1: return 1;
      2: return 2;
      3, 5, 6: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic bit nxt_fb(input int nm, input int cm, input bit f);
    if (nm == 3) return (kind(cm) == 3) ? !f : 1'b0;
    if (nm == 6) return 1'b1;
    return 1'b0;
  endfunction

  task automatic m_load();
    m_fb   = nxt_fb(int'(mode), m_mode, m_fb);
    m_mode = int'(mode);
    m_pal  = pal;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_h = 0; m_v = 0; m_mode = 0; m_pal = 0; m_fb = 0; m_ehq = 1; m_evq = 1;
    end else begin
      int idx, L, T;
      bit hf, vf, wrap;
      idx = (m_pal ? 4 : 0) + kind(m_mode);
      L = ltab[idx];
      T = ttab[idx];
      hf = m_ehq && !ext_hd;
      vf = m_evq && !ext_vd;
      if (int_en) begin
        wrap = (m_h == LINE-1 && ((T == 0) ? (m_v >= L-1) : (m_v >= L))) ||
               (T != 0 && m_v >= L && m_h == T-1);
        if (wrap) begin
          m_h = 0; m_v = 0; m_load();
        end else if (m_h == LINE-1) begin
          m_h = 0; m_v = (m_v == 2**VW-1) ? m_v : m_v + 1;
        end else m_h++;
      end else begin
        if (vf) begin
          m_v = 0; m_load();
          m_h = hf ? 0 : ((m_h == LINE-1) ? m_h : m_h + 1);
        end else if (hf) begin
          m_h = 0; m_v = (m_v == 2**VW-1) ? m_v : m_v + 1;
        end else m_h = (m_h == LINE-1) ? m_h : m_h + 1;
      end
      m_ehq = ext_hd;
      m_evq = ext_vd;
    end
  end

  always @(negedge clk) begin
    bit e_hd, e_vd;
    e_hd = int_en ? (m_h >= HDW) : m_ehq;
    e_vd = int_en ? (m_v >= VDL) : m_evq;
    chk(int'(hc) == m_h, "R1 h_cnt", int'(hc), m_h);
    chk(int'(vc) == m_v, "R3 v_cnt", int'(vc), m_v);
    chk(hd == e_hd, "R1 hd", int'(hd), int'(e_hd));
    chk(vd == e_vd, "R4 vd", int'(vd), int'(e_vd));
    chk(fb == m_fb, "R6 field", int'(fb), int'(m_fb));
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic set_in(input logic [2:0] m, input logic p);
    @(negedge clk); #1;
    mode = m; pal = p;
  endtask

  task automatic wait_vd_fall();
    logic prev;
    do begin
      prev = vd;
      @(negedge clk);
    end while (!(prev && !vd));
  endtask

  task automatic count_to_fall(inout int n);
    logic prev;
    do begin
      prev = vd;
      @(negedge clk);
      n++;
    end while (!(prev && !vd));
  endtask

  task automatic meas(input logic [2:0] m, input logic p, input int idx, input string req);
    int n = 0;
    set_in(m, p);
    wait_vd_fall();
    count_to_fall(n);
    chk(n == ltab[idx]*LINE + ttab[idx], req, n, ltab[idx]*LINE + ttab[idx]);
  endtask

  initial begin
    int n;
    // R9: reset state
    repeat (2) @(negedge clk);
    chk(hc == 0 && vc == 0, "R9 reset counts", int'(hc) + int'(vc), 0);
    chk(hd == 0 && vd == 0, "R9 reset strobes", int'(hd) + int'(vd), 0);
    chk(fb == 0, "R9 reset field", int'(fb), 0);
    #1 rst_n = 1;
    // R9: first field is NTSC draft even though mode_i says AF2
    n = 0;
    count_to_fall(n);
    chk(n == ltab[0]*LINE + ttab[0], "R9 first field length", n, ltab[0]*LINE + ttab[0]);

    // R2 / R3: every table entry, both standards, aliases
    meas(3'b000, 1'b0, 0, "R2 ntsc draft");
    meas(3'b001, 1'b0, 1, "R2 ntsc af1");
    meas(3'b010, 1'b0, 2, "R3 ntsc af2 zero tail");
    meas(3'b011, 1'b0, 3, "R2 ntsc frame");
    meas(3'b000, 1'b1, 4, "R2 pal draft");
    meas(3'b001, 1'b1, 5, "R3 pal af1 long tail");
    meas(3'b010, 1'b1, 6, "R3 pal af2 one-clock tail");
    meas(3'b011, 1'b1, 7, "R2 pal frame");
    meas(3'b100, 1'b0, 0, "R2 code 100 is draft");
    meas(3'b111, 1'b1, 4, "R2 code 111 is draft");
    meas(3'b101, 1'b0, 3, "R2 code 101 is frame");
    meas(3'b110, 1'b1, 7, "R2 code 110 is frame");

    // R5: change mid-field has no effect on current field
    set_in(3'b011, 1'b0);
    wait_vd_fall();
    n = 0;
    repeat (10) begin @(negedge clk); n++; end
    #1 mode = 3'b010; pal = 1'b1;
    n--;  // the #1 is inside the last counted cycle
    n++;
    count_to_fall(n);
    chk(n == ltab[3]*LINE + ttab[3], "R5 mid-field change ignored", n, ltab[3]*LINE + ttab[3]);
    n = 0;
    count_to_fall(n);
    chk(n == ltab[6]*LINE + ttab[6], "R5 change taken at next field", n, ltab[6]*LINE + ttab[6]);

    // R6: alternation starting from a non-frame field
    set_in(3'b011, 1'b0);
    wait_vd_fall();
    chk(fb == 0, "R6 first frame field A", int'(fb), 0);
    wait_vd_fall();
    chk(fb == 1, "R6 second frame field B", int'(fb), 1);
    wait_vd_fall();
    chk(fb == 0, "R6 third frame field A", int'(fb), 0);

    // R7: forced fields
    set_in(3'b110, 1'b0);
    wait_vd_fall();
    chk(fb == 1, "R7 forced B", int'(fb), 1);
    wait_vd_fall();
    chk(fb == 1, "R7 forced B repeat", int'(fb), 1);
    set_in(3'b101, 1'b0);
    wait_vd_fall();
    chk(fb == 0, "R7 forced A", int'(fb), 0);
    set_in(3'b011, 1'b0);
    wait_vd_fall();
    chk(fb == 1, "R6 toggle after forced A", int'(fb), 1);
    set_in(3'b001, 1'b0);
    wait_vd_fall();
    chk(fb == 0, "R7 non-frame gives A", int'(fb), 0);

    // R8: external sync with irregular spacing
    set_in(3'b011, 1'b1);
    #0 int_en = 0;
    for (int k = 0; k < 8; k++) begin
      repeat (7 + 3*k) @(negedge clk);
      #1 ext_hd = 0;
      if (k == 2 || k == 6) ext_vd = 0;
      @(negedge clk);
      chk(hc == 0, "R8 h_cnt cleared by ext edge", int'(hc), 0);
      chk(hd == 0, "R8 hd follows ext", int'(hd), 0);
      if (k == 2 || k == 6) chk(vc == 0, "R8 v_cnt cleared by ext vd", int'(vc), 0);
      #1 ext_hd = 1; ext_vd = 1;
      @(negedge clk);
      chk(hd == 1, "R8 hd released", int'(hd), 1);
    end

    // back to internal generation
    #1 int_en = 1;
    repeat (400) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule